// File: doc/BRIEF.md
# Register Result Status Rename Table

This block tracks, for each of 32 floating-point registers of 64 bits, which reservation station will produce its next value. When an instruction issues, the table answers two source lookups in the same cycle. For each source it returns either the register's stored value or the 4-bit tag of the station that will produce it. On the next clock edge it records the issuing station's tag as the new producer of the destination register.

The block also snoops the result bus. A broadcast is written into a register only if that register is still waiting on exactly the broadcast tag. A later issue to the same register therefore supersedes an earlier one, and the earlier producer's result is dropped for that register. This removes write-after-write and write-after-read hazards on the register file.

Tag value 0 is the empty encoding, so stations are numbered 1 to 15. Each register entry is a two-state machine:
- ENT_READY: the value is valid and the tag is 0.
- ENT_WAIT: a producer tag is pending.

The entry moves between states as follows:
- claim: any state goes to ENT_WAIT with the new tag.
- match: ENT_WAIT goes to ENT_READY when the bus carries its tag and no claim arrives in the same cycle.
- otherwise: the entry holds its state.

Top module: `rrs_rename_table`

## Requirements
- R1: After reset every register is in ENT_READY with value 0, so every lookup returns tag 0 and value 0.
- R2: A lookup of a register in ENT_READY, with no bypass active, returns tag 0 and the stored value, in the same cycle.
- R3: A lookup of a register in ENT_WAIT whose tag is not on the bus returns the pending tag and value 0.
- R4: A claim records its tag at the next edge and overwrites any earlier pending tag. A claim requires iss_valid=1, iss_dst_en=1 and a nonzero iss_tag.
- R5: A bus result with bus_valid=1 and bus_tag equal to a waiting register's tag writes bus_data into that register and returns it to ENT_READY. A result with any other tag leaves the register's value and state unchanged, including the tag of a producer that has been superseded.
- R6: When a matching bus result and a claim hit the same register in one cycle, the register ends in ENT_WAIT holding the claim's tag.
- R7: A lookup sees the status from before any claim made in the same cycle, so an instruction that reads and writes one register gets the older producer.
- R8: A lookup of a waiting register whose tag is on the bus in the same cycle returns bus_data with tag 0.
- R9: If iss_valid=0, iss_dst_en=0, or iss_tag=0, no register's status changes.
- R10: One bus result updates every register that is waiting on its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_dst_en | input | 1 | The instruction writes a destination |
| iss_dst | input | 5 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station (0 means none) |
| src_a_tag | output | 4 | Producer tag for source a (0 means value valid) |
| src_a_val | output | 64 | Value for source a |
| src_b_tag | output | 4 | Producer tag for source b |
| src_b_val | output | 64 | Value for source b |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | 4 | Tag of the station that produced the result |
| bus_data | input | 64 | Result data |

## Verification
Directed patterns come first. A single producer is claimed and then broadcast, which separates the pending case from the ready case and the bypass path from the registered path. Two back-to-back claims on one register show whether the superseded tag is ignored. A claim that coincides with a matching broadcast shows whether the new tag wins. Read-and-write of the same register shows whether the lookup sees the old status, and one tag shared by two registers shows whether the write reaches both. Disabled claims of three kinds show they leave the entry alone. A long random stretch then mixes claims and broadcasts drawn from the pending tags, and its lookups are compared against a model built from the requirements.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic {
        ENT_READY = 1'b0,
        ENT_WAIT  = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rrs_entry.sv
module rrs_entry
    import rrs_pkg::*;
#(
    parameter int DW = 64,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim,
    input  logic [TW-1:0] new_tag,
    input  logic          bus_valid,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_data,
    output logic [TW-1:0] rd_tag,
    output logic [DW-1:0] rd_val
);
    ent_state_e    state_q, state_d;
    logic [TW-1:0] tag_q, tag_d;
    logic [DW-1:0] value_q;
    logic          hit;

    assign hit = (state_q == ENT_WAIT) && bus_valid && (bus_tag == tag_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            ENT_READY: begin
                if (claim) begin
                    state_d = ENT_WAIT;
                    tag_d   = new_tag;
                end
            end
            ENT_WAIT: begin
                if (claim) begin
                    tag_d = new_tag;
                end else if (hit) begin
                    state_d = ENT_READY;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = ENT_READY;
                tag_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            if (hit) value_q <= bus_data;
        end
    end

    // outputs with same-cycle bypass
    always_comb begin
        rd_tag = '0;
        rd_val = '0;
        unique case (state_q)
            ENT_READY: rd_val = value_q;
            ENT_WAIT: begin
                if (hit) rd_val = bus_data;
                else     rd_tag = tag_q;
            end
            default: ;
        endcase
    end

    a_r4_claim_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (state_q == ENT_WAIT) && (tag_q == $past(new_tag)));
    a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !claim) |=> (state_q == ENT_READY) && (value_q == $past(bus_data)));
    a_r5_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> value_q == $past(value_q));
    a_r3_wait_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_WAIT) |-> (tag_q != '0));
endmodule

// File: rtl/rrs_read_mux.sv
module rrs_read_mux #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int TW   = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][TW-1:0] tag_arr,
    input  logic [NREG-1:0][DW-1:0] val_arr,
    input  logic [IW-1:0]           sel,
    output logic [TW-1:0]           tag_o,
    output logic [DW-1:0]           val_o
);
    assign tag_o = tag_arr[sel];
    assign val_o = val_arr[sel];
endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int TW   = 4,
    localparam int IW  = $clog2(NREG),
    localparam int NSRC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [IW-1:0] iss_src_a,
    input  logic [IW-1:0] iss_src_b,
    input  logic          iss_dst_en,
    input  logic [IW-1:0] iss_dst,
    input  logic [TW-1:0] iss_tag,
    output logic [TW-1:0] src_a_tag,
    output logic [DW-1:0] src_a_val,
    output logic [TW-1:0] src_b_tag,
    output logic [DW-1:0] src_b_val,
    input  logic          bus_valid,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_data
);
    logic [NREG-1:0][TW-1:0] ent_tag;
    logic [NREG-1:0][DW-1:0] ent_val;
    logic                    claim_ok;
    logic [NSRC-1:0][IW-1:0] src_sel;
    logic [NSRC-1:0][TW-1:0] src_tag;
    logic [NSRC-1:0][DW-1:0] src_val;

    assign claim_ok = iss_valid && iss_dst_en && (iss_tag != '0);

    for (genvar r = 0; r < NREG; r++) begin : g_ent
        rrs_entry #(.DW(DW), .TW(TW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim    (claim_ok && (iss_dst == IW'(r))),
            .new_tag  (iss_tag),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_data (bus_data),
            .rd_tag   (ent_tag[r]),
            .rd_val   (ent_val[r])
        );
    end

    assign src_sel[0] = iss_src_a;
    assign src_sel[1] = iss_src_b;

    for (genvar p = 0; p < NSRC; p++) begin : g_rd
        rrs_read_mux #(.NREG(NREG), .DW(DW), .TW(TW)) u_mux (
            .tag_arr(ent_tag),
            .val_arr(ent_val),
            .sel    (src_sel[p]),
            .tag_o  (src_tag[p]),
            .val_o  (src_val[p])
        );
    end

    assign src_a_tag = src_tag[0];
    assign src_a_val = src_val[0];
    assign src_b_tag = src_tag[1];
    assign src_b_val = src_val[1];

    a_r3_tag_hides_value: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_tag != '0) |-> (src_a_val == '0));
    a_r8_bus_tag_never_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tag != '0) |-> (src_a_tag != bus_tag) && (src_b_tag != bus_tag));
endmodule

// File: tb/rrs_rename_table_tb_top.sv
module rrs_rename_table_tb_top;
    localparam int NREG = 32;
    localparam int DW   = 64;
    localparam int TW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, iss_dst_en = 1'b0, bus_valid = 1'b0;
    logic [4:0]    iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [TW-1:0] iss_tag = '0, bus_tag = '0;
    logic [DW-1:0] bus_data = '0;
    logic [TW-1:0] src_a_tag, src_b_tag;
    logic [DW-1:0] src_a_val, src_b_val;

    always #4 clk = ~clk;

    rrs_rename_table dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .src_a_tag(src_a_tag), .src_a_val(src_a_val),
        .src_b_tag(src_b_tag), .src_b_val(src_b_val),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    typedef struct {
        string         lbl;
        logic [TW-1:0] ta, tb;
        logic [DW-1:0] va, vb;
    } exp_t;

    exp_t          q[$];
    int            n_chk = 0, n_fail = 0;
    logic [TW-1:0] mtag [NREG];
    logic [DW-1:0] mval [NREG];

    // scoreboard monitor: compares mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (src_a_tag !== e.ta || src_a_val !== e.va) begin
                n_fail++;
                $display("FAIL %s port a: got tag=%0d val=%h expected tag=%0d val=%h",
                         e.lbl, src_a_tag, src_a_val, e.ta, e.va);
            end
            n_chk++;
            if (src_b_tag !== e.tb || src_b_val !== e.vb) begin
                n_fail++;
                $display("FAIL %s port b: got tag=%0d val=%h expected tag=%0d val=%h",
                         e.lbl, src_b_tag, src_b_val, e.tb, e.vb);
            end
        end
    end

    function automatic void predict(input logic [4:0] s, input logic bv,
                                    input logic [TW-1:0] bt, input logic [DW-1:0] bd,
                                    output logic [TW-1:0] t, output logic [DW-1:0] v);
        if (mtag[s] != 0 && bv && bt == mtag[s]) begin t = '0; v = bd; end
        else if (mtag[s] != 0) begin t = mtag[s]; v = '0; end
        else begin t = '0; v = mval[s]; end
    endfunction

    // driver: drives one cycle, pushes expectation, then advances the model
    task automatic step(input logic iv, input logic [4:0] sa, input logic [4:0] sb,
                        input logic de, input logic [4:0] d, input logic [TW-1:0] it,
                        input logic bv, input logic [TW-1:0] bt, input logic [DW-1:0] bd,
                        input string lbl);
        exp_t e;
        @(posedge clk); #1;
        iss_valid = iv; iss_src_a = sa; iss_src_b = sb; iss_dst_en = de;
        iss_dst = d; iss_tag = it; bus_valid = bv; bus_tag = bt; bus_data = bd;
        e.lbl = lbl;
        predict(sa, bv, bt, bd, e.ta, e.va);
        predict(sb, bv, bt, bd, e.tb, e.vb);
        q.push_back(e);
        for (int r = 0; r < NREG; r++) begin
            logic m;
            m = (mtag[r] != 0) && bv && (bt == mtag[r]);
            if (m) mval[r] = bd;
            if (iv && de && it != 0 && d == 5'(r)) mtag[r] = it;
            else if (m) mtag[r] = '0;
        end
    endtask

    task automatic look(input logic [4:0] sa, input logic [4:0] sb, input string lbl);
        step(1'b0, sa, sb, 1'b0, 5'd0, 4'd0, 1'b0, 4'd0, 64'd0, lbl);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : stim
        for (int r = 0; r < NREG; r++) begin mtag[r] = '0; mval[r] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look(5'd0, 5'd31, "R1 reset state");
        // R7: read r3 while claiming it
        step(1, 5'd3, 5'd3, 1, 5'd3, 4'd5, 0, 4'd0, 64'd0, "R7 lookup before claim");
        look(5'd3, 5'd0, "R3 pending tag");
        step(0, 5'd3, 5'd1, 0, 5'd0, 4'd0, 1, 4'd5, 64'hA5A5_0000_1111_2222, "R8 bypass");
        look(5'd3, 5'd3, "R2 ready value after R5 write");
        // superseded producer
        step(1, 5'd4, 5'd4, 1, 5'd4, 4'd6, 0, 4'd0, 64'd0, "R4 first claim");
        step(1, 5'd4, 5'd4, 1, 5'd4, 4'd7, 0, 4'd0, 64'd0, "R4 overwrite sees old tag");
        step(0, 5'd4, 5'd3, 0, 5'd0, 4'd0, 1, 4'd6, 64'hBBBB, "R5 superseded tag ignored");
        look(5'd4, 5'd3, "R5 no change after stale tag");
        step(0, 5'd4, 5'd0, 0, 5'd0, 4'd0, 1, 4'd7, 64'hCCCC_CCCC, "R8 bypass latest");
        look(5'd4, 5'd4, "R5 latest producer written");
        // R6
        step(1, 5'd8, 5'd0, 1, 5'd8, 4'd2, 0, 4'd0, 64'd0, "R4 claim r8");
        step(1, 5'd8, 5'd8, 1, 5'd8, 4'd3, 1, 4'd2, 64'hDDDD, "R6 collide bypass");
        look(5'd8, 5'd8, "R6 new tag wins");
        step(0, 5'd8, 5'd0, 0, 5'd0, 4'd0, 1, 4'd3, 64'hEEEE, "R8 bypass r8");
        look(5'd8, 5'd8, "R5 r8 written");
        // R9 disabled claims
        step(1, 5'd10, 5'd10, 0, 5'd10, 4'd9, 0, 4'd0, 64'd0, "R9 dst_en low");
        look(5'd10, 5'd10, "R9 dst_en low no change");
        step(1, 5'd10, 5'd10, 1, 5'd10, 4'd0, 0, 4'd0, 64'd0, "R9 zero tag");
        look(5'd10, 5'd10, "R9 zero tag no change");
        step(0, 5'd10, 5'd10, 1, 5'd10, 4'd9, 0, 4'd0, 64'd0, "R9 valid low");
        look(5'd10, 5'd10, "R9 valid low no change");
        // R10 shared tag
        step(1, 5'd12, 5'd13, 1, 5'd12, 4'd9, 0, 4'd0, 64'd0, "R10 claim r12");
        step(1, 5'd12, 5'd13, 1, 5'd13, 4'd9, 0, 4'd0, 64'd0, "R10 claim r13");
        step(0, 5'd12, 5'd13, 0, 5'd0, 4'd0, 1, 4'd9, 64'hF00D, "R10 broadcast bypass");
        look(5'd12, 5'd13, "R10 both written");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0]    pick;
            logic [TW-1:0] bt;
            pick = 5'($urandom_range(0, NREG - 1));
            bt = (mtag[pick] != 0) ? mtag[pick] : 4'($urandom_range(0, 15));
            step(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 4'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), bt, {$urandom, $urandom}, "R3 random mix");
        end
        look(5'd0, 5'd1, "R2 final");
        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule